// File: doc/BRIEF.md
# Staged Pattern Pulse Generator

This block drives a 16-bit pulse pattern made of four 4-bit groups. Software stages the next pattern in a staging register. Each group watches the compare-match strobe it has been assigned. When that strobe arrives, the staged bits of that group move onto the pins. Nothing else in the chip has to act at that moment, so the pin timing follows the timer and not the software.

Each output bit has its own enable. A bit whose enable is low keeps its present value across transfers. Each group can be driven inverted. Each group can also run in a non-overlap mode. In that mode, bits falling from 1 to 0 change at the group's primary trigger. Bits rising from 0 to 1 are held back until a second, separately selected trigger closes the margin. This keeps complementary edges apart. When a transfer completes, the group pulses a done strobe for one cycle so that software or a DMA engine can restage the pattern.

Each group runs a two-state machine. The states are `G_IDLE` (waiting for the primary trigger) and `G_MARGIN` (falls applied, rises pending). The transitions are:
- **IDLE→IDLE (direct)**: primary trigger with non-overlap off. All enabled bits load and done pulses.
- **IDLE→MARGIN (split)**: primary trigger with non-overlap on. Enabled falling bits clear and the rising bits are latched as pending.
- **MARGIN→IDLE (close)**: margin trigger. The pending rises are applied and done pulses.

Top module: `pattern_pulse_gen`

## Requirements
- R1: After reset all pins are 0 and all done strobes are 0. The staging, enable, select and mode registers all read as zero, which means no inversion and no non-overlap.
- R2: The register map is selected by `wr_addr`: 0 = staging pattern, 1 = per-bit enable, 2 = trigger selects, 3 = mode. A write to the staging register never changes the pins until a trigger moves it.
- R3: In register 2, bits [2g+1:2g] pick which `cmp_match` index is group g's primary trigger. Only the groups that select an asserted strobe transfer. Every other group's pins stay unchanged.
- R4: A bit whose enable bit (register 1, same bit position) is 0 keeps its output value through any transfer.
- R5: Register 3 bit g inverts group g's pins immediately. Rise and fall are judged on the non-inverted value.
- R6: Register 3 bit 4+g selects non-overlap for group g. At the primary trigger, only the enabled 1→0 bits change. The enabled 0→1 bits change at the margin trigger, which is selected by register 2 bits [9+2g:8+2g].
- R7: `xfer_done[g]` is high for exactly the cycle in which group g's pins complete a transfer. The pins update on the clock edge that samples the trigger.
- R8: While a group waits in its margin, further primary triggers and new staging writes do not change which rises are applied at the margin end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| cmp_match | input | 4 | Compare-match strobes from the timer |
| pulse_out | output | 16 | Pattern pins |
| xfer_done | output | 4 | Per-group transfer-complete strobe |

## Verification
The hardest situation to reach is the margin window of a non-overlap group. A group has to hold falls already applied and rises pending while other groups share its triggers, a second primary trigger arrives, and the staging register is rewritten. The stimulus gets there with a pattern of mixed rises and falls. It then fires the primary trigger and, before the margin trigger, repeats that trigger and overwrites the staged data. Finally it shows that the margin end applies only the rises captured earlier.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic [0:0] {
        G_IDLE   = 1'b0,
        G_MARGIN = 1'b1
    } grp_state_e;

    localparam logic [1:0] ADDR_STAGE = 2'd0;
    localparam logic [1:0] ADDR_EN    = 2'd1;
    localparam logic [1:0] ADDR_TSEL  = 2'd2;
    localparam logic [1:0] ADDR_MODE  = 2'd3;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int GW     = 4,
    parameter int SELW   = 2,
    localparam int OUT_W = GROUPS * GW,
    localparam int PSW   = GROUPS * SELW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [OUT_W-1:0]  wr_data,
    output logic [OUT_W-1:0]  stage_q,
    output logic [OUT_W-1:0]  en_q,
    output logic [PSW-1:0]    psel_q,
    output logic [PSW-1:0]    msel_q,
    output logic [GROUPS-1:0] inv_q,
    output logic [GROUPS-1:0] nov_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            en_q    <= '0;
            psel_q  <= '0;
            msel_q  <= '0;
            inv_q   <= '0;
            nov_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_STAGE: stage_q <= wr_data;
                ADDR_EN:    en_q    <= wr_data;
                ADDR_TSEL: begin
                    psel_q <= wr_data[PSW-1:0];
                    msel_q <= wr_data[2*PSW-1:PSW];
                end
                ADDR_MODE: begin
                    inv_q <= wr_data[GROUPS-1:0];
                    nov_q <= wr_data[2*GROUPS-1:GROUPS];
                end
            endcase
        end
    end
endmodule

// File: rtl/ppg_group.sv
module ppg_group
    import ppg_pkg::*;
#(
    parameter int GW    = 4,
    parameter int SELW  = 2,
    localparam int NTRIG = 1 << SELW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] cmp_match,
    input  logic [SELW-1:0]  psel,
    input  logic [SELW-1:0]  msel,
    input  logic             nov,
    input  logic [GW-1:0]    stage,
    input  logic [GW-1:0]    en,
    output logic [GW-1:0]    out_q,
    output logic             done_q
);
    grp_state_e    state_q, state_d;
    logic [GW-1:0] pend_q, pend_d, out_d;
    logic          done_d;
    logic          ptrig, mtrig;
    logic [GW-1:0] rise, fall;

    assign ptrig = cmp_match[psel];
    assign mtrig = cmp_match[msel];
    assign rise  = en & stage & ~out_q;
    assign fall  = en & ~stage & out_q;

    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        pend_d  = pend_q;
        done_d  = 1'b0;
        unique case (state_q)
            G_IDLE: begin
                if (ptrig) begin
                    if (nov) begin
                        out_d   = out_q & ~fall;
                        pend_d  = rise;
                        state_d = G_MARGIN;
                    end else begin
                        out_d  = (out_q & ~en) | (stage & en);
                        done_d = 1'b1;
                    end
                end
            end
            G_MARGIN: begin
                if (mtrig) begin
                    out_d   = out_q | pend_q;
                    pend_d  = '0;
                    done_d  = 1'b1;
                    state_d = G_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= G_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            pend_q <= '0;
            done_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            pend_q <= pend_d;
            done_q <= done_d;
        end
    end
endmodule

// File: rtl/pattern_pulse_gen.sv
module pattern_pulse_gen #(
    parameter int GROUPS = 4,
    parameter int GW     = 4,
    parameter int SELW   = 2,
    localparam int OUT_W = GROUPS * GW,
    localparam int NTRIG = 1 << SELW,
    localparam int PSW   = GROUPS * SELW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [OUT_W-1:0]  wr_data,
    input  logic [NTRIG-1:0]  cmp_match,
    output logic [OUT_W-1:0]  pulse_out,
    output logic [GROUPS-1:0] xfer_done
);
    logic [OUT_W-1:0]  stage_q, en_q, level_q;
    logic [PSW-1:0]    psel_q, msel_q;
    logic [GROUPS-1:0] inv_q, nov_q;

    ppg_regs #(.GROUPS(GROUPS), .GW(GW), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stage_q(stage_q), .en_q(en_q),
        .psel_q(psel_q), .msel_q(msel_q), .inv_q(inv_q), .nov_q(nov_q)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ppg_group #(.GW(GW), .SELW(SELW)) u_grp (
            .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match),
            .psel(psel_q[g*SELW +: SELW]), .msel(msel_q[g*SELW +: SELW]),
            .nov(nov_q[g]), .stage(stage_q[g*GW +: GW]), .en(en_q[g*GW +: GW]),
            .out_q(level_q[g*GW +: GW]), .done_q(xfer_done[g])
        );
        assign pulse_out[g*GW +: GW] = level_q[g*GW +: GW] ^ {GW{inv_q[g]}};
    end
endmodule

// File: rtl/ppg_chk.sv
module ppg_chk #(
    parameter int GROUPS = 4,
    parameter int GW     = 4,
    parameter int SELW   = 2,
    localparam int OUT_W = GROUPS * GW,
    localparam int NTRIG = 1 << SELW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [NTRIG-1:0]  cmp_match,
    input logic [OUT_W-1:0]  pulse_out,
    input logic [GROUPS-1:0] xfer_done,
    input logic [OUT_W-1:0]  level_q,
    input logic [OUT_W-1:0]  en_q
);
    // R2
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match == '0 && !(wr_en && wr_addr == 2'd3)) |=> $stable(pulse_out));

    // R4
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((level_q ^ $past(level_q)) & ~$past(en_q)) == '0));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done != '0) |-> ($past(cmp_match) != '0));

    for (genvar g = 0; g < GROUPS; g++) begin : g_rise
        // R6
        rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((level_q[g*GW +: GW] & ~$past(level_q[g*GW +: GW])) != '0)
            |-> xfer_done[g]);
    end
endmodule

bind pattern_pulse_gen ppg_chk #(.GROUPS(GROUPS), .GW(GW), .SELW(SELW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cmp_match(cmp_match), .pulse_out(pulse_out), .xfer_done(xfer_done),
    .level_q(level_q), .en_q(en_q)
);

// File: tb/pattern_pulse_gen_tb.sv
module pattern_pulse_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  cmp_match = '0;
    logic [15:0] pulse_out;
    logic [3:0]  xfer_done;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] pins;
        logic [3:0]  done;
        string       tag;
    } exp_t;
    exp_t sb[$];
    exp_t it;

    always #4 clk = ~clk;

    pattern_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_match(cmp_match),
        .pulse_out(pulse_out), .xfer_done(xfer_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            it = sb.pop_front();
            checks++;
            if (pulse_out !== it.pins || xfer_done !== it.done) begin
                fails++;
                $display("FAIL %s: pins=%h done=%b expected pins=%h done=%b",
                         it.tag, pulse_out, xfer_done, it.pins, it.done);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [3:0] m, input logic [15:0] p,
                        input logic [3:0] dn, input string tag);
        exp_t e;
        cmp_match = m;
        e.due = cyc + 1; e.pins = p; e.done = dn; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        cmp_match = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fire(4'b0000, 16'h0000, 4'b0000, "R1 reset state");
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'h00E4);
        wr(2'd0, 16'h1234);
        fire(4'b0000, 16'h0000, 4'b0000, "R2 staged not on pins");
        fire(4'b0001, 16'h0004, 4'b0001, "R3 group0 on cmp0");
        fire(4'b0000, 16'h0004, 4'b0000, "R7 done single cycle");
        wr(2'd0, 16'hABCD);
        fire(4'b1110, 16'hABC4, 4'b1110, "R3 groups1-3");
        wr(2'd1, 16'h0F0F);
        wr(2'd0, 16'h5555);
        fire(4'b1111, 16'hA5C5, 4'b1111, "R4 per-bit enable");
        wr(2'd3, 16'h0002);
        fire(4'b0000, 16'hA535, 4'b0000, "R5 invert group1");
        wr(2'd2, 16'h00E6);
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'h0000);
        fire(4'b0001, 16'hA535, 4'b0000, "R3 unselected strobe");
        fire(4'b0100, 16'hA030, 4'b0101, "R3 shared select");
        wr(2'd3, 16'h0012);
        wr(2'd2, 16'h03E6);
        wr(2'd0, 16'hA003);
        fire(4'b0100, 16'hA030, 4'b0100, "R6 rises held at primary");
        fire(4'b1000, 16'hA033, 4'b1001, "R6 rises at margin");
        wr(2'd0, 16'hA00C);
        fire(4'b0100, 16'hA030, 4'b0100, "R6 falls at primary");
        wr(2'd0, 16'hA00F);
        fire(4'b0100, 16'hA030, 4'b0100, "R8 retrigger in margin");
        fire(4'b0000, 16'hA030, 4'b0000, "R8 margin wait");
        fire(4'b1000, 16'hA03C, 4'b1001, "R8 captured rises only");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d pending expected 0", sb.size());
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule